// File: doc/BRIEF.md
# Cache Early Termination Controller

This controller sits beside a 32-bit processor bus that has an external cache attached. It acknowledges a read bus cycle early, with no wait states by default, on the assumption that the cache will hit. It does this before the hit result is known. The decision rests on a status bit that was stored when the previous bus cycle ended, together with a decode of the current cycle. That decode covers the transfer direction, the function code, the CPU-space indication, the processor's cache-inhibit output and a cachable-region input.

When a cycle that was acknowledged early turns out to miss, the controller drives bus error and halt low together. This makes the processor retry the cycle. The missed cycle leaves a suppressed status behind, so the retry completes through normal external termination. A parameter inserts clocked delay stages between the decision and the acknowledge, one stage for each wait state.

Top module: `cacheEarlyTerm`

## Requirements
- R1: Reset leaves the stored status in the suppressed state and all three outputs high. The first bus cycle after reset is never acknowledged early.
- R2: A clock is eligible when all of the following hold: `asN` is low, `rdWrN` is 1 (read), `cachableRegion` is 1, `cacheInhibit` is 0, `cpuSpace` is 0, and `fnCode` is not 3'b111.
- R3: `earlyAckN` goes low when the stored status permits and the current clock is eligible. With WAIT_STATES = 0 it falls in the same clock period in which `asN` is first low. It then stays low while `asN` stays low and the clock stays eligible.
- R4: On each clock edge where `asN` is sampled high after having been low, the status is stored as permitted only if the last clock of that cycle was eligible and had `cacheHit` = 1.
- R5: A cycle that is inhibited, misses or is outside the cachable region suppresses early acknowledge for the whole of the following cycle.
- R6: If `cacheHit` is 0 in a clock where `earlyAckN` is low, then `berrN` and `haltN` both go low from the next clock. They always carry equal values.
- R7: `berrN` and `haltN` return high on the clock after `asN` is sampled high. The retried cycle is not acknowledged early.
- R8: Write cycles (`rdWrN` = 0) never get `earlyAckN` low.
- R9: CPU-space cycles never get `earlyAckN` low, whether they are marked by `cpuSpace` = 1 or by `fnCode` = 3'b111.
- R10: With WAIT_STATES = N, `earlyAckN` falls exactly N clocks later than it would with N = 0, and it is still released when `asN` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| asN | input | 1 | Address strobe, active low |
| rdWrN | input | 1 | 1 = read, 0 = write |
| fnCode | input | FC_WIDTH | Processor function code |
| cpuSpace | input | 1 | External CPU-space decode, active high |
| cacheInhibit | input | 1 | Processor cache-inhibit output, active high |
| cacheHit | input | 1 | Cache hit from the tag compare, active high |
| cachableRegion | input | 1 | Address lies in a cachable region |
| earlyAckN | output | 1 | Early cycle termination, active low |
| berrN | output | 1 | Bus error, active low |
| haltN | output | 1 | Halt, active low |

## Verification
Some properties hold in every clock, and the bound assertions check these continuously. They are:
- `berrN` and `haltN` move together.
- No acknowledge is given outside the address strobe, on writes, or on CPU-space cycles.
- Bus error releases after the strobe negates.
- Bus error only starts after an acknowledged miss.

Other behaviour depends on history across cycles, so only the bench's scenarios can show it. This covers:
- the status stored at the end of one cycle and used in the next,
- suppression after an inhibited, missed or non-cachable cycle,
- the suppressed retry,
- the exact clock at which the acknowledge falls under different wait-state settings.

The bench checks these against a cycle model, for an instance with zero wait states and one with two.

// File: rtl/ctPkg.sv
package ctPkg;
  // strobes from the bus-phase control to the datapath
  typedef struct packed {
    logic busOn;    // address strobe asserted this clock
    logic asRise;   // strobe negated after being asserted: end of cycle
    logic endLate;  // release any pending late termination
  } ctStrobe_t;
endpackage

// File: rtl/ctCtrl.sv
module ctCtrl
  import ctPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      asN,
  output ctStrobe_t strobe
);
  logic asPrev;

  always_ff @(posedge clk) begin
    if (!rstN) asPrev <= 1'b1;
    else       asPrev <= asN;
  end

  always_comb begin
    strobe.busOn   = !asN;
    strobe.asRise  = asN && !asPrev;
    strobe.endLate = asN;
  end
endmodule

// File: rtl/ctPath.sv
module ctPath
  import ctPkg::*;
#(
  parameter int WAIT_STATES = 0,
  parameter int FC_WIDTH = 3,
  parameter logic [FC_WIDTH-1:0] CPU_FC = '1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctStrobe_t           strobe,
  input  logic                rdWrN,
  input  logic [FC_WIDTH-1:0] fnCode,
  input  logic                cpuSpace,
  input  logic                cacheInhibit,
  input  logic                cacheHit,
  input  logic                cachableRegion,
  output logic                earlyAckN,
  output logic                berrN,
  output logic                haltN
);
  logic eligible;
  logic lastElig;
  logic lastHit;
  logic statusOk;
  logic term0;
  logic ackRaw;
  logic late;

  always_comb begin
    eligible = strobe.busOn && rdWrN && cachableRegion && !cacheInhibit &&
               !cpuSpace && (fnCode != CPU_FC);
    term0 = statusOk && eligible;
  end

  // last sampled condition of the running cycle, stored when the strobe rises
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastElig <= 1'b0;
      lastHit  <= 1'b0;
      statusOk <= 1'b0;
    end else begin
      if (strobe.busOn) begin
        lastElig <= eligible;
        lastHit  <= cacheHit;
      end
      if (strobe.asRise) statusOk <= lastElig && lastHit;
    end
  end

  generate
    if (WAIT_STATES == 0) begin : gNoWait
      assign ackRaw = term0;
    end else begin : gWait
      logic [WAIT_STATES-1:0] stage;
      always_ff @(posedge clk) begin
        if (!rstN) stage <= '0;
        else begin
          stage[0] <= term0;
          for (int i = 1; i < WAIT_STATES; i++)
            stage[i] <= stage[i-1] && strobe.busOn;
        end
      end
      assign ackRaw = stage[WAIT_STATES-1] && eligible;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)               late <= 1'b0;
    else if (strobe.endLate) late <= 1'b0;
    else if (ackRaw && !cacheHit) late <= 1'b1;
  end

  assign earlyAckN = !ackRaw;
  assign berrN     = !late;
  assign haltN     = !late;
endmodule

// File: rtl/cacheEarlyTerm.sv
module cacheEarlyTerm
  import ctPkg::*;
#(
  parameter int WAIT_STATES = 0,
  parameter int FC_WIDTH = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                asN,
  input  logic                rdWrN,
  input  logic [FC_WIDTH-1:0] fnCode,
  input  logic                cpuSpace,
  input  logic                cacheInhibit,
  input  logic                cacheHit,
  input  logic                cachableRegion,
  output logic                earlyAckN,
  output logic                berrN,
  output logic                haltN
);
  ctStrobe_t strobe;

  ctCtrl uCtrl (
    .clk(clk), .rstN(rstN), .asN(asN), .strobe(strobe)
  );

  ctPath #(.WAIT_STATES(WAIT_STATES), .FC_WIDTH(FC_WIDTH)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdWrN(rdWrN),
    .fnCode(fnCode), .cpuSpace(cpuSpace), .cacheInhibit(cacheInhibit),
    .cacheHit(cacheHit), .cachableRegion(cachableRegion),
    .earlyAckN(earlyAckN), .berrN(berrN), .haltN(haltN)
  );
endmodule

// File: rtl/ctCheck.sv
module ctCheck (
  input logic clk,
  input logic rstN,
  input logic asN,
  input logic rdWrN,
  input logic cpuSpace,
  input logic cacheHit,
  input logic earlyAckN,
  input logic berrN,
  input logic haltN
);
  AST_BERR_HALT_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    berrN == haltN); // R6
  AST_ACK_IN_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    asN |-> earlyAckN); // R3
  AST_WRITE_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (!asN && !rdWrN) |-> earlyAckN); // R8
  AST_CPU_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    cpuSpace |-> earlyAckN); // R9
  AST_LATE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    asN |=> berrN); // R7
  AST_LATE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(berrN) |-> $past(!earlyAckN && !cacheHit)); // R6
endmodule

bind cacheEarlyTerm ctCheck uChk (
  .clk(clk), .rstN(rstN), .asN(asN), .rdWrN(rdWrN), .cpuSpace(cpuSpace),
  .cacheHit(cacheHit), .earlyAckN(earlyAckN), .berrN(berrN), .haltN(haltN)
);

// File: tb/cacheEarlyTerm_test.sv
module cacheEarlyTerm_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic asN = 1'b1, rdWrN = 1'b1, cpuSpace = 1'b0, cacheInhibit = 1'b0;
  logic cacheHit = 1'b0, cachableRegion = 1'b0;
  logic [2:0] fnCode = 3'b001;
  logic ack0, berr0, halt0, ack1, berr1, halt1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  cacheEarlyTerm #(.WAIT_STATES(0)) uut (
    .clk(clk), .rstN(rstN), .asN(asN), .rdWrN(rdWrN), .fnCode(fnCode),
    .cpuSpace(cpuSpace), .cacheInhibit(cacheInhibit), .cacheHit(cacheHit),
    .cachableRegion(cachableRegion), .earlyAckN(ack0), .berrN(berr0), .haltN(halt0));

  cacheEarlyTerm #(.WAIT_STATES(2)) uutWait (
    .clk(clk), .rstN(rstN), .asN(asN), .rdWrN(rdWrN), .fnCode(fnCode),
    .cpuSpace(cpuSpace), .cacheInhibit(cacheInhibit), .cacheHit(cacheHit),
    .cachableRegion(cachableRegion), .earlyAckN(ack1), .berrN(berr1), .haltN(halt1));

  typedef struct {
    logic ack[2];
    logic berr[2];
    string tag;
  } item_t;
  item_t sbq[$];

  // reference model state, index 0: no wait, index 1: two wait states
  logic mAsPrev[2], mLastElig[2], mLastHit[2], mStatus[2], mLate[2];
  logic [3:0] mStage[2];
  string curTag = "R1";

  task automatic chk(input logic act, input logic exp, input string what, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic a, input logic rd, input logic rg, input logic cpu,
                      input logic [2:0] fc, input logic inh, input logic hit);
    item_t it;
    @(negedge clk);
    asN = a; rdWrN = rd; cachableRegion = rg; cpuSpace = cpu;
    fnCode = fc; cacheInhibit = inh; cacheHit = hit;
    for (int k = 0; k < 2; k++) begin
      int w;
      logic elig, term0, ackRaw;
      w = (k == 0) ? 0 : 2;
      elig = !a && rd && rg && !inh && !cpu && (fc != 3'b111);
      term0 = mStatus[k] && elig;
      ackRaw = (w == 0) ? term0 : (mStage[k][w-1] && elig);
      it.ack[k] = !ackRaw;
      it.berr[k] = !mLate[k];
      // next state
      if (a) mLate[k] = 1'b0;
      else if (ackRaw && !hit) mLate[k] = 1'b1;
      if (a && !mAsPrev[k]) mStatus[k] = mLastElig[k] && mLastHit[k];
      if (!a) begin mLastElig[k] = elig; mLastHit[k] = hit; end
      mStage[k] = {mStage[k][2:0] & {3{!a}}, term0};
      mAsPrev[k] = a;
    end
    it.tag = curTag;
    sbq.push_back(it);
  endtask

  task automatic busCycle(input logic rd, input logic rg, input logic cpu, input logic [2:0] fc,
                          input logic inh, input logic hit, input int len);
    for (int i = 0; i < len; i++) step(1'b0, rd, rg, cpu, fc, inh, hit);
    step(1'b1, rd, rg, cpu, fc, inh, hit);
  endtask

  // monitor: compare each clock against the queued expectation
  always @(negedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      item_t e;
      e = sbq.pop_front();
      chk(ack0, e.ack[0], "earlyAckN(w0)", e.tag);
      chk(berr0, e.berr[0], "berrN(w0)", e.tag);
      chk(halt0, e.berr[0], "haltN(w0)", e.tag);
      chk(ack1, e.ack[1], "earlyAckN(w2)", e.tag);
      chk(berr1, e.berr[1], "berrN(w2)", e.tag);
      chk(halt1, e.berr[1], "haltN(w2)", e.tag);
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      mAsPrev[k] = 1; mLastElig[k] = 0; mLastHit[k] = 0;
      mStatus[k] = 0; mLate[k] = 0; mStage[k] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: outputs idle after reset
    chk(ack0, 1'b1, "earlyAckN after reset", "R1");
    chk(berr0, 1'b1, "berrN after reset", "R1");
    chk(ack1, 1'b1, "earlyAckN(w2) after reset", "R1");
    curTag = "R1 first cycle";
    busCycle(1, 1, 0, 3'b001, 0, 1, 4);
    curTag = "R3 R10 early ack hit";
    busCycle(1, 1, 0, 3'b010, 0, 1, 4);
    curTag = "R6 acked miss";
    busCycle(1, 1, 0, 3'b001, 0, 0, 4);
    curTag = "R7 retry suppressed";
    busCycle(1, 1, 0, 3'b001, 0, 1, 4);
    busCycle(1, 1, 0, 3'b001, 0, 1, 4);
    curTag = "R5 inhibited";
    busCycle(1, 1, 0, 3'b001, 1, 1, 4);
    curTag = "R5 after inhibit";
    busCycle(1, 1, 0, 3'b001, 0, 1, 4);
    curTag = "R4 non-cachable";
    busCycle(1, 0, 0, 3'b001, 0, 1, 3);
    busCycle(1, 1, 0, 3'b001, 0, 1, 4);
    busCycle(1, 1, 0, 3'b001, 0, 1, 4);
    curTag = "R8 write";
    busCycle(0, 1, 0, 3'b001, 0, 1, 4);
    busCycle(1, 1, 0, 3'b001, 0, 1, 4);
    curTag = "R9 cpu space input";
    busCycle(1, 1, 1, 3'b001, 0, 1, 4);
    busCycle(1, 1, 0, 3'b001, 0, 1, 4);
    curTag = "R9 R2 fc cpu space";
    busCycle(1, 1, 0, 3'b111, 0, 1, 4);
    curTag = "R10 wait miss";
    busCycle(1, 1, 0, 3'b001, 0, 1, 4);
    busCycle(1, 1, 0, 3'b001, 0, 0, 5);
    curTag = "R2 random";
    for (int n = 0; n < 250; n++) begin
      logic [3:0] pick;
      int len;
      pick = 4'($urandom_range(0, 15));
      len = $urandom_range(1, 5);
      busCycle(pick != 0, pick != 1, pick == 2, (pick == 3) ? 3'b111 : 3'b101,
               pick == 4, pick < 11, len);
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule